// File: doc/BRIEF.md
# Clock Source Enable and Status Controller

This block holds the control and status state of a microcontroller clock unit with two sources: an internal generator and an external generator. Software reaches it through a byte-wide register port with one write strobe. The port holds the enable bit of each generator, a 7-bit multiplier factor for the internal generator and an 8-bit trim value. The block also derives one "stable" flag per generator. The oscillators, the frequency measurement and the clock multiplexer lie outside the block. They supply the clock-select bit, the monitor-enable bit, the per-source dead-clock indications, the stop-mode signals, a synchronized one-cycle external tick and an in-range indication for the internal clock.

Each enable bit is held on while the clock-select and monitor conditions need that generator. Software can turn an enable off only once the releasing condition has held for a full bus cycle. The external stable flag is a start-up delay that counts external ticks. The internal stable flag follows the in-range qualifier and is dropped by a list of disturbing events. The multiplier register is locked while the monitor is enabled, and a stored zero is presented to the generator as one.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset the internal enable is 1, the external enable is 0, both stable flags are 0, the multiplier field is 0x15 and the trim value is 0x80.
- R2: If monitor-enable is 1 or clock-select is 0 at a clock edge, the internal enable is 1 after that edge.
- R3: Writing 1 to the internal enable always sets it. Writing 0 clears it only when clock-select was 1 and monitor-enable was 0 at both the write edge and the edge before it.
- R4: If monitor-enable or clock-select is 1 at a clock edge, the external enable is 1 after that edge.
- R5: Writing 1 to the external enable always sets it. Writing 0 clears it only when clock-select and monitor-enable were both 0 at both the write edge and the edge before it.
- R6: The external stable flag becomes 1 on the edge that counts the STARTUP_TICKS-th external tick since the external enable was last 1 without a clear. It then stays 1 (the counter saturates) until a clear condition occurs.
- R7: The external stable flag and its tick count go to 0 after any edge at which the external clock is reported dead, the external enable is 0, or stop is requested while keep-in-stop is 0.
- R8: The internal stable flag becomes 1 after an edge where in-range is 1, no clear condition is active and no multiplier or trim write occurred on the previous edge. Once set, it stays 1 until a clear condition occurs.
- R9: The internal stable flag is 0 after any edge with the internal clock reported dead, the internal enable 0, a write to the multiplier or trim address (locked or not), or stop requested while keep-in-stop is 0.
- R10: A multiplier write while monitor-enable is 1 changes neither the stored field nor the factor output.
- R11: The factor output equals the stored 7-bit field, except that a stored 0 is presented as 1. Readback returns the stored field unchanged, with bit 7 read as 0.
- R12: The register map is: address 0 = control (bit0 internal enable, bit1 internal stable, bit2 external enable, bit3 external stable, other bits read 0); address 1 = multiplier; address 2 = trim; address 3 reads 0. Writes to the stable bit positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| clk_sel | input | 1 | Clock select: 1 = external source in use |
| mon_en | input | 1 | Clock monitor enable |
| int_clk_dead | input | 1 | Monitor reports the internal clock inactive |
| ext_clk_dead | input | 1 | Monitor reports the external clock inactive |
| stop_req | input | 1 | Stop mode active |
| osc_keep_in_stop | input | 1 | Oscillators kept running during stop |
| ext_tick | input | 1 | Synchronized one-cycle pulse per external clock period |
| int_in_range | input | 1 | Internal clock measured within range |
| int_gen_en | output | 1 | Internal generator enable |
| ext_gen_en | output | 1 | External generator enable |
| int_stable | output | 1 | Internal clock stable flag |
| ext_stable | output | 1 | External clock stable flag |
| mult_factor | output | MULT_W | Effective multiplier factor for the generator |
| trim_value | output | TRIM_W | Trim value for the generator |

## Verification
The bench builds the block with STARTUP_TICKS set to 16 instead of 4096. The external start-up flag then sets, saturates and is cleared and re-armed many times within a short run, under both directed and random tick patterns. The other parameters keep their defaults, so the 7-bit zero alias, the 0x15 reset factor and the bit-7 readback rule are tested at their real width. The long random phase holds clock-select and monitor-enable for varying spans, which drives the one-cycle qualification of enable clears both just inside and just outside its window.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  // register offsets (decoded by software)
  localparam int CTRL_OFS = 0;
  localparam int MULT_OFS = 1;
  localparam int TRIM_OFS = 2;
  // control register bit positions
  localparam int B_INT_EN = 0;
  localparam int B_INT_ST = 1;
  localparam int B_EXT_EN = 2;
  localparam int B_EXT_ST = 3;

  typedef struct packed {
    logic ctrl;
    logic mult;
    logic trim;
  } wr_hit_t;
endpackage

// File: rtl/clksrc_gen_enable.sv
// One generator enable bit: forced on by the source conditions, cleared by
// software only after the releasing condition has held for a full cycle.
module clksrc_gen_enable #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_on,
  input  logic clr_ok_now,
  input  logic wr,
  input  logic wbit,
  output logic en,
  output logic clr_ok_held
);
  logic ok_q;
  logic clr_take;

  assign clr_ok_held = ok_q & clr_ok_now;
  assign clr_take    = wr & ~wbit & clr_ok_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
      en   <= RST_VAL;
    end else begin
      ok_q <= clr_ok_now;
      if (force_on)      en <= 1'b1;
      else if (wr && wbit) en <= 1'b1;
      else if (clr_take) en <= 1'b0;
    end
  end
endmodule

// File: rtl/clksrc_startup_timer.sv
// Counts external ticks after enable; saturates at TICKS.
module clksrc_startup_timer #(
  parameter int TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clear)              cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/clksrc_int_qualifier.sv
// Internal stable flag: set by in-range, dropped by disturbances, held off
// for one cycle after a factor or trim write.
module clksrc_int_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic reval,
  input  logic in_range,
  output logic stable
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      stable <= 1'b0;
    end else begin
      hold_q <= reval;
      if (clear)                    stable <= 1'b0;
      else if (!hold_q && in_range) stable <= 1'b1;
    end
  end
endmodule

// File: rtl/clksrc_factor_regs.sv
// Multiplier factor (lockable, zero aliased to one) and trim storage.
module clksrc_factor_regs #(
  parameter int MULT_W   = 7,
  parameter int MULT_RST = 21,
  parameter int TRIM_W   = 8,
  parameter int TRIM_RST = 128,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mult,
  input  logic              wr_trim,
  input  logic              lock,
  input  logic [DATA_W-1:0] wdata,
  output logic [MULT_W-1:0] mult_raw,
  output logic [MULT_W-1:0] mult_eff,
  output logic [TRIM_W-1:0] trim
);
  function automatic logic [MULT_W-1:0] alias_zero(input logic [MULT_W-1:0] f);
    return (f == '0) ? MULT_W'(1) : f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_raw <= MULT_W'(MULT_RST);
      trim     <= TRIM_W'(TRIM_RST);
    end else begin
      if (wr_mult && !lock) mult_raw <= wdata[MULT_W-1:0];
      if (wr_trim)          trim     <= wdata[TRIM_W-1:0];
    end
  end

  assign mult_eff = alias_zero(mult_raw);
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl #(
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8,
  parameter int MULT_W        = 7,
  parameter int MULT_RST      = 21,
  parameter int TRIM_W        = 8,
  parameter int TRIM_RST      = 128,
  parameter int STARTUP_TICKS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              clk_sel,
  input  logic              mon_en,
  input  logic              int_clk_dead,
  input  logic              ext_clk_dead,
  input  logic              stop_req,
  input  logic              osc_keep_in_stop,
  input  logic              ext_tick,
  input  logic              int_in_range,
  output logic              int_gen_en,
  output logic              ext_gen_en,
  output logic              int_stable,
  output logic              ext_stable,
  output logic [MULT_W-1:0] mult_factor,
  output logic [TRIM_W-1:0] trim_value
);
  import clksrc_pkg::*;

  // named internal events
  wr_hit_t     hit;
  logic        wr_ctrl, wr_mult, wr_trim;
  logic        stop_kill;
  logic        int_force, ext_force;
  logic        int_clr_ok, ext_clr_ok;
  logic        int_clr_held, ext_clr_held;
  logic        ext_st_clear, int_st_clear;
  logic [MULT_W-1:0] mult_raw;

  assign hit.ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit.mult = bus_wr && (bus_addr == ADDR_W'(MULT_OFS));
  assign hit.trim = bus_wr && (bus_addr == ADDR_W'(TRIM_OFS));
  assign wr_ctrl  = hit.ctrl;
  assign wr_mult  = hit.mult;
  assign wr_trim  = hit.trim;

  assign stop_kill  = stop_req & ~osc_keep_in_stop;
  assign int_force  = mon_en | ~clk_sel;
  assign ext_force  = mon_en | clk_sel;
  assign int_clr_ok = clk_sel & ~mon_en;
  assign ext_clr_ok = ~clk_sel & ~mon_en;

  clksrc_gen_enable #(.RST_VAL(1'b1)) u_int_en (
    .clk(clk), .rst_n(rst_n),
    .force_on(int_force), .clr_ok_now(int_clr_ok),
    .wr(wr_ctrl), .wbit(bus_wdata[B_INT_EN]),
    .en(int_gen_en), .clr_ok_held(int_clr_held)
  );

  clksrc_gen_enable #(.RST_VAL(1'b0)) u_ext_en (
    .clk(clk), .rst_n(rst_n),
    .force_on(ext_force), .clr_ok_now(ext_clr_ok),
    .wr(wr_ctrl), .wbit(bus_wdata[B_EXT_EN]),
    .en(ext_gen_en), .clr_ok_held(ext_clr_held)
  );

  assign ext_st_clear = ext_clk_dead | ~ext_gen_en | stop_kill;

  clksrc_startup_timer #(.TICKS(STARTUP_TICKS)) u_ext_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(ext_st_clear), .tick(ext_tick),
    .done(ext_stable)
  );

  assign int_st_clear = int_clk_dead | ~int_gen_en | wr_mult | wr_trim | stop_kill;

  clksrc_int_qualifier u_int_qual (
    .clk(clk), .rst_n(rst_n),
    .clear(int_st_clear), .reval(wr_mult | wr_trim),
    .in_range(int_in_range), .stable(int_stable)
  );

  clksrc_factor_regs #(
    .MULT_W(MULT_W), .MULT_RST(MULT_RST),
    .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST), .DATA_W(DATA_W)
  ) u_factors (
    .clk(clk), .rst_n(rst_n),
    .wr_mult(wr_mult), .wr_trim(wr_trim), .lock(mon_en),
    .wdata(bus_wdata),
    .mult_raw(mult_raw), .mult_eff(mult_factor), .trim(trim_value)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(CTRL_OFS): begin
        bus_rdata[B_INT_EN] = int_gen_en;
        bus_rdata[B_INT_ST] = int_stable;
        bus_rdata[B_EXT_EN] = ext_gen_en;
        bus_rdata[B_EXT_ST] = ext_stable;
      end
      ADDR_W'(MULT_OFS): bus_rdata[MULT_W-1:0] = mult_raw;
      ADDR_W'(TRIM_OFS): bus_rdata[TRIM_W-1:0] = trim_value;
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk #(
  parameter int MULT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_sel,
  input logic              mon_en,
  input logic              int_clk_dead,
  input logic              ext_clk_dead,
  input logic              stop_kill,
  input logic              ext_tick,
  input logic              int_in_range,
  input logic              wr_mult,
  input logic              wr_trim,
  input logic              int_gen_en,
  input logic              ext_gen_en,
  input logic              int_stable,
  input logic              ext_stable,
  input logic [MULT_W-1:0] mult_factor
);
  p_int_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en || !clk_sel) |=> int_gen_en);

  p_int_clear_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_gen_en) |-> ($past(clk_sel && !mon_en) && $past(clk_sel && !mon_en, 2)));

  p_ext_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en || clk_sel) |=> ext_gen_en);

  p_ext_clear_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_gen_en) |-> ($past(!clk_sel && !mon_en) && $past(!clk_sel && !mon_en, 2)));

  p_ext_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_stable) |-> $past(ext_tick));

  p_ext_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_dead || !ext_gen_en || stop_kill) |=> !ext_stable);

  p_int_rise_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stable) |-> ($past(int_in_range) && !$past(wr_mult || wr_trim)));

  p_int_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk_dead || !int_gen_en || wr_mult || wr_trim || stop_kill) |=> !int_stable);

  p_mult_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mult && mon_en) |=> $stable(mult_factor));

  p_mult_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mult_factor != '0);
endmodule

bind clksrc_ctrl clksrc_ctrl_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mon_en(mon_en),
  .int_clk_dead(int_clk_dead), .ext_clk_dead(ext_clk_dead),
  .stop_kill(stop_kill), .ext_tick(ext_tick), .int_in_range(int_in_range),
  .wr_mult(wr_mult), .wr_trim(wr_trim),
  .int_gen_en(int_gen_en), .ext_gen_en(ext_gen_en),
  .int_stable(int_stable), .ext_stable(ext_stable),
  .mult_factor(mult_factor)
);

// File: tb/test_clksrc_ctrl.sv
`timescale 1ns/1ps
module test_clksrc_ctrl;
  localparam int TICKS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       clk_sel = 1'b0, mon_en = 1'b0;
  logic       int_clk_dead = 1'b0, ext_clk_dead = 1'b0;
  logic       stop_req = 1'b0, osc_keep_in_stop = 1'b1;
  logic       ext_tick = 1'b0, int_in_range = 1'b0;
  logic       int_gen_en, ext_gen_en, int_stable, ext_stable;
  logic [6:0] mult_factor;
  logic [7:0] trim_value;

  always #10 clk = ~clk;

  clksrc_ctrl #(.STARTUP_TICKS(TICKS)) i_clksrc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
    .mon_en(mon_en), .int_clk_dead(int_clk_dead), .ext_clk_dead(ext_clk_dead),
    .stop_req(stop_req), .osc_keep_in_stop(osc_keep_in_stop),
    .ext_tick(ext_tick), .int_in_range(int_in_range),
    .int_gen_en(int_gen_en), .ext_gen_en(ext_gen_en),
    .int_stable(int_stable), .ext_stable(ext_stable),
    .mult_factor(mult_factor), .trim_value(trim_value)
  );

  // reference model state
  bit m_int_en, m_ext_en, m_int_st, m_hold, m_int_prev_ok, m_ext_prev_ok;
  int m_cnt;
  int m_mult, m_trim;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    // R1 reset values
    m_int_en = 1; m_ext_en = 0; m_int_st = 0; m_hold = 0;
    m_int_prev_ok = 0; m_ext_prev_ok = 0; m_cnt = 0;
    m_mult = 'h15; m_trim = 'h80;
  endtask

  task automatic model_edge();
    bit w_c, w_m, w_t, kill, n_int, n_ext, n_st, n_hold;
    int n_cnt;
    if (!rst_n) begin model_reset(); return; end
    w_c  = bus_wr && bus_addr == 0;
    w_m  = bus_wr && bus_addr == 1;
    w_t  = bus_wr && bus_addr == 2;
    kill = stop_req && !osc_keep_in_stop;
    // R2 / R3
    n_int = m_int_en;
    if (mon_en || !clk_sel) n_int = 1;
    else if (w_c && bus_wdata[0]) n_int = 1;
    else if (w_c && m_int_prev_ok) n_int = 0;
    // R4 / R5
    n_ext = m_ext_en;
    if (mon_en || clk_sel) n_ext = 1;
    else if (w_c && bus_wdata[2]) n_ext = 1;
    else if (w_c && m_ext_prev_ok) n_ext = 0;
    // R6 / R7
    n_cnt = m_cnt;
    if (ext_clk_dead || !m_ext_en || kill) n_cnt = 0;
    else if (ext_tick && m_cnt < TICKS) n_cnt = m_cnt + 1;
    // R8 / R9
    n_st = m_int_st;
    if (int_clk_dead || !m_int_en || w_m || w_t || kill) n_st = 0;
    else if (!m_hold && int_in_range) n_st = 1;
    n_hold = w_m || w_t;
    // R10 / R12
    if (w_m && !mon_en) m_mult = bus_wdata & 'h7f;
    if (w_t) m_trim = bus_wdata;
    m_int_prev_ok = clk_sel && !mon_en;
    m_ext_prev_ok = !clk_sel && !mon_en;
    m_int_en = n_int; m_ext_en = n_ext; m_cnt = n_cnt;
    m_int_st = n_st; m_hold = n_hold;
  endtask

  task automatic compare();
    int exp_rd;
    bit ext_done;
    ext_done = (m_cnt == TICKS);
    chk("R3 int_gen_en", int_gen_en, m_int_en);
    chk("R5 ext_gen_en", ext_gen_en, m_ext_en);
    chk("R6 ext_stable", ext_stable, ext_done);
    chk("R8 int_stable", int_stable, m_int_st);
    chk("R11 mult_factor", mult_factor, (m_mult == 0) ? 1 : m_mult);
    chk("R1 trim_value", trim_value, m_trim);
    case (bus_addr)
      2'd0: exp_rd = {4'b0, ext_done, m_ext_en, m_int_st, m_int_en};
      2'd1: exp_rd = m_mult;
      2'd2: exp_rd = m_trim;
      default: exp_rd = 0;
    endcase
    chk("R12 bus_rdata", bus_rdata, exp_rd);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    step();
    bus_wr = 0;
  endtask

  task automatic rd(int a);
    bus_addr = 2'(a);
    step();
  endtask

  initial begin
    model_reset();
    steps(3);
    rst_n = 1;
    // R1: reset state on every register
    rd(0); rd(1); rd(2); rd(3);
    // R2: cs=0 forces internal on; a clear write is refused
    wr(0, 'h00);
    // R4/R5: external forced on by cs, then cleared after cs=0 held a cycle
    clk_sel = 1; steps(2);
    clk_sel = 0; step();
    wr(0, 'h01);
    // R5: cs drops in the same cycle as the write -> refused
    clk_sel = 1; step();
    clk_sel = 0; wr(0, 'h01);
    wr(0, 'h04);           // R5 write of 1 sets external enable
    // R3: cs=1 held, internal clear accepted; then set by write of 1
    clk_sel = 1; steps(2);
    wr(0, 'h04);
    wr(0, 'h05);
    // R3: monitor on forbids clear
    mon_en = 1; wr(0, 'h04); mon_en = 0;
    wr(0, 'h04);           // previous cycle had mon_en=1 -> refused
    // R6: start-up count, saturation
    ext_tick = 1; steps(TICKS + 4); ext_tick = 0; steps(2);
    // R7: dead clock and stop clear the count
    ext_clk_dead = 1; step(); ext_clk_dead = 0;
    ext_tick = 1; steps(TICKS / 2);
    stop_req = 1; osc_keep_in_stop = 0; step();
    osc_keep_in_stop = 1; steps(TICKS + 2); stop_req = 0; ext_tick = 0;
    // R8: in-range sets internal stable; R9 write clears; holdoff
    int_in_range = 1; steps(3);
    wr(1, 'h10); steps(3);
    wr(2, 'h7f); steps(2);
    int_clk_dead = 1; step(); int_clk_dead = 0; steps(2);
    int_in_range = 0; steps(2);
    // R11: zero alias and readback
    wr(1, 'h00); rd(1);
    wr(1, 'hff); rd(1);
    // R10: lock while monitor enabled
    mon_en = 1; wr(1, 'h2a); rd(1); mon_en = 0; step();
    // R12: write to stable positions ignored, unused address
    wr(0, 'hff); rd(0); wr(3, 'hff); rd(3);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 15) == 0) clk_sel = ~clk_sel;
      if ($urandom_range(0, 23) == 0) mon_en = ~mon_en;
      int_clk_dead     = ($urandom_range(0, 63) == 0);
      ext_clk_dead     = ($urandom_range(0, 127) == 0);
      stop_req         = ($urandom_range(0, 63) == 0);
      osc_keep_in_stop = ($urandom_range(0, 1) == 0);
      ext_tick         = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 31) == 0) int_in_range = ~int_in_range;
      bus_wr    = ($urandom_range(0, 7) == 0);
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wdata = 8'($urandom_range(0, 255));
      step();
    end
    bus_wr = 0;
    steps(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule